// File: doc/BRIEF.md
# Smart Panel Command Sequencer

This block runs a stream of 16-bit command words against a command-mode LCD panel. The panel sits on an 8-bit parallel bus with a register-select line (A0), an active-low write strobe and an active-low read strobe. Each word is offered on a valid/ready input. The sequencer decodes the word and does one of the following: a timed bus write, a timed bus read, a wait for the next frame-sync edge, a delay counted in milliseconds, an interrupt flag, or nothing.

A read returns its byte in a status word. That word also carries the A0 value of the read, a completion (OK) flag and a continue flag. After every read the sequencer stops taking words until software sets the continue flag. The sequencer then consumes the flag and goes on. Two pending flags, one for completed reads and one for interrupt commands, combine through per-flag masks into one interrupt line.

Top module: `panel_cmd_seq`

## Requirements
- R1: After reset, cmd_ready is 1, both strobes are high (inactive), pnl_doe is 0, rd_status is 0, and both pending flags and irq are 0.
- R2: A word with opcode field [11:9]=1 (A0 from bit 8), or opcode 2 with bit 8 set, is a write of the data byte in bits [7:0]. The block drives pnl_a0 and pnl_dout with pnl_doe high for one setup cycle. It then holds pnl_wr_n low for STROBE_CYC cycles and keeps the data for one hold cycle, so cmd_ready is low for STROBE_CYC+2 cycles. pnl_dout and pnl_a0 do not change while the strobe is low.
- R3: Opcode 0 is a read from the select given by bit 8. There is one setup cycle, then pnl_rd_n stays low for STROBE_CYC cycles and pnl_din is sampled in the last of them, then there is one hold cycle. rd_status holds the byte in bits [7:0], the read's A0 in bit 8 and OK in bit 9. OK is cleared when a read is accepted and is set when its byte is captured. Capture sets pend_rd.
- R4: After a read, cmd_ready stays low until sw_continue has set the continue flag (rd_status bit 10). The cycle after the flag is seen, the flag clears and cmd_ready returns. A flag set before the read is accepted is discarded at acceptance.
- R5: Opcode 3 completes only on a low-to-high change of frame_sync seen after acceptance. A level that is already high does not complete it. cmd_ready returns the cycle after the rising edge is sampled.
- R6: Opcode 6 holds cmd_ready low for N×CYC_PER_MS cycles, where N is bits [7:0]. N=0 is consumed in the accept cycle with no stall.
- R7: Opcode 5 sets pend_cmd.
- R8: irq is (pend_rd and not mask_rd) or (pend_cmd and not mask_cmd). sw_clr_rd and sw_clr_cmd clear their flags. A set in the same cycle wins over the clear.
- R9: Opcodes 4 and 7, and opcode 2 with bit 8 clear, are consumed in one cycle. They cause no strobe, no flag and no change to pnl_dout or pnl_a0.
- R10: cmd_ready is high only while the sequencer is idle. No strobe and no pnl_doe occur while it is high. Words with cmd_valid low are never taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_word | input | 16 | Command word: [7:0] data, [8] A0, [11:9] opcode |
| cmd_ready | output | 1 | Sequencer idle, word accepted when valid |
| pnl_a0 | output | 1 | Panel register select |
| pnl_dout | output | 8 | Panel write data |
| pnl_doe | output | 1 | Panel data output enable |
| pnl_din | input | 8 | Panel read data |
| pnl_wr_n | output | 1 | Active-low write strobe |
| pnl_rd_n | output | 1 | Active-low read strobe |
| frame_sync | input | 1 | Frame sync from the panel timing |
| sw_continue | input | 1 | Pulse that sets the continue flag |
| sw_clr_rd | input | 1 | Clears the read pending flag |
| sw_clr_cmd | input | 1 | Clears the command interrupt flag |
| mask_rd | input | 1 | Masks the read flag from irq |
| mask_cmd | input | 1 | Masks the command flag from irq |
| rd_status | output | 16 | Read-status word: [7:0] byte, [8] A0, [9] OK, [10] continue |
| pend_rd | output | 1 | Read completion pending |
| pend_cmd | output | 1 | Command interrupt pending |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bench sets the continue flag before a read is issued. A design that kept that early flag would run past the read without a stall. Frame sync is held high across the acceptance of a vsync wait. A level-sensitive design would finish at once instead of waiting for the next rising edge. A delay of zero is checked for no stall and a nonzero delay for its exact cycle count; an off-by-one counter shows up as one extra or one missing busy cycle. The opcode-2-without-A0 and opcode-7 words check that unused encodings neither strobe the bus nor overwrite the data byte. A clear and a set that meet in the same cycle check that the pending flag survives.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        OP_READ  = 3'd0,
        OP_WRITE = 3'd1,
        OP_FRAME = 3'd2,
        OP_VSYNC = 3'd3,
        OP_NOP   = 3'd4,
        OP_IRQ   = 3'd5,
        OP_DELAY = 3'd6,
        OP_SPARE = 3'd7
    } pcs_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WR_SETUP,
        ST_WR_STB,
        ST_WR_HOLD,
        ST_RD_SETUP,
        ST_RD_STB,
        ST_RD_HOLD,
        ST_WAIT_CONT,
        ST_WAIT_VS,
        ST_DELAY
    } pcs_state_e;

    function automatic pcs_op_e op_of(input logic [WORD_W-1:0] w);
        return pcs_op_e'(w[11:9]);
    endfunction

endpackage

// File: rtl/pcs_ms_delay.sv
module pcs_ms_delay #(
    parameter int CYC_PER_MS = 100000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [pcs_pkg::BYTE_W-1:0] ms_in,
    output logic                      done
);
    localparam int SUB_W = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
    localparam logic [SUB_W-1:0] SUB_TOP = SUB_W'(CYC_PER_MS - 1);

    typedef struct packed {
        logic                       act;
        logic [pcs_pkg::BYTE_W-1:0] ms;
        logic [SUB_W-1:0]           sub;
    } dly_t;

    dly_t r_q, r_d;

    assign done = r_q.act && (r_q.ms == 1) && (r_q.sub == '0);

    always_comb begin
        r_d = r_q;
        if (start) begin
            r_d.act = 1'b1;
            r_d.ms  = ms_in;
            r_d.sub = SUB_TOP;
        end else if (r_q.act) begin
            if (r_q.sub == '0) begin
                if (r_q.ms == 1) begin
                    r_d.act = 1'b0;
                end else begin
                    r_d.ms  = r_q.ms - 1'b1;
                    r_d.sub = SUB_TOP;
                end
            end else begin
                r_d.sub = r_q.sub - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/pcs_status.sv
module pcs_status (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rd_begin,
    input  logic                        rd_done,
    input  logic [pcs_pkg::BYTE_W-1:0]  rd_byte,
    input  logic                        rd_a0,
    input  logic                        cont_set,
    input  logic                        cont_take,
    input  logic                        cmd_int,
    input  logic                        clr_rd,
    input  logic                        clr_cmd,
    input  logic                        mask_rd,
    input  logic                        mask_cmd,
    output logic [pcs_pkg::WORD_W-1:0]  stat_word,
    output logic                        cont_flag,
    output logic                        pend_rd,
    output logic                        pend_cmd,
    output logic                        irq
);
    typedef struct packed {
        logic [pcs_pkg::BYTE_W-1:0] dat;
        logic                       a0;
        logic                       ok;
        logic                       cont;
        logic                       pr;
        logic                       pc;
    } stat_t;

    stat_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        // clears first, sets afterwards so a same-cycle set wins
        if (rd_begin) begin
            s_d.ok   = 1'b0;
            s_d.cont = 1'b0;
        end
        if (cont_take) s_d.cont = 1'b0;
        if (cont_set)  s_d.cont = 1'b1;
        if (rd_done) begin
            s_d.dat = rd_byte;
            s_d.a0  = rd_a0;
            s_d.ok  = 1'b1;
        end
        if (clr_rd)  s_d.pr = 1'b0;
        if (rd_done) s_d.pr = 1'b1;
        if (clr_cmd) s_d.pc = 1'b0;
        if (cmd_int) s_d.pc = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign stat_word = {5'b0, s_q.cont, s_q.ok, s_q.a0, s_q.dat};
    assign cont_flag = s_q.cont;
    assign pend_rd   = s_q.pr;
    assign pend_cmd  = s_q.pc;
    assign irq       = (s_q.pr && !mask_rd) || (s_q.pc && !mask_cmd);
endmodule

// File: rtl/panel_cmd_seq.sv
module panel_cmd_seq #(
    parameter int STROBE_CYC = 2,
    parameter int CYC_PER_MS = 100000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic [15:0] cmd_word,
    output logic        cmd_ready,
    output logic        pnl_a0,
    output logic [7:0]  pnl_dout,
    output logic        pnl_doe,
    input  logic [7:0]  pnl_din,
    output logic        pnl_wr_n,
    output logic        pnl_rd_n,
    input  logic        frame_sync,
    input  logic        sw_continue,
    input  logic        sw_clr_rd,
    input  logic        sw_clr_cmd,
    input  logic        mask_rd,
    input  logic        mask_cmd,
    output logic [15:0] rd_status,
    output logic        pend_rd,
    output logic        pend_cmd,
    output logic        irq
);
    import pcs_pkg::*;

    localparam int SCNT_W = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1;
    localparam logic [SCNT_W-1:0] SCNT_TOP = SCNT_W'(STROBE_CYC - 1);

    typedef struct packed {
        pcs_state_e          st;
        logic [SCNT_W-1:0]   cnt;
        logic                a0;
        logic [BYTE_W-1:0]   dat;
        logic                vs;
    } seq_t;

    seq_t q_q, q_d;

    logic rd_begin, rd_done, cont_take, cmd_int, dly_start, dly_done, cont_flag;
    logic unused_hi;
    pcs_op_e op;
    logic    w_a0;
    logic [BYTE_W-1:0] w_dat;

    assign unused_hi = ^cmd_word[15:12];
    assign op    = op_of(cmd_word);
    assign w_a0  = cmd_word[8];
    assign w_dat = cmd_word[7:0];

    always_comb begin
        q_d       = q_q;
        q_d.vs    = frame_sync;
        rd_begin  = 1'b0;
        rd_done   = 1'b0;
        cont_take = 1'b0;
        cmd_int   = 1'b0;
        dly_start = 1'b0;
        unique case (q_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    unique case (op)
                        OP_READ: begin
                            q_d.a0   = w_a0;
                            q_d.st   = ST_RD_SETUP;
                            rd_begin = 1'b1;
                        end
                        OP_WRITE: begin
                            q_d.a0  = w_a0;
                            q_d.dat = w_dat;
                            q_d.st  = ST_WR_SETUP;
                        end
                        OP_FRAME: begin
                            if (w_a0) begin
                                q_d.a0  = 1'b1;
                                q_d.dat = w_dat;
                                q_d.st  = ST_WR_SETUP;
                            end
                        end
                        OP_VSYNC: q_d.st = ST_WAIT_VS;
                        OP_IRQ:   cmd_int = 1'b1;
                        OP_DELAY: begin
                            if (w_dat != '0) begin
                                dly_start = 1'b1;
                                q_d.st    = ST_DELAY;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            ST_WR_SETUP: begin
                q_d.cnt = SCNT_TOP;
                q_d.st  = ST_WR_STB;
            end
            ST_WR_STB: begin
                if (q_q.cnt == '0) q_d.st  = ST_WR_HOLD;
                else               q_d.cnt = q_q.cnt - 1'b1;
            end
            ST_WR_HOLD: q_d.st = ST_IDLE;
            ST_RD_SETUP: begin
                q_d.cnt = SCNT_TOP;
                q_d.st  = ST_RD_STB;
            end
            ST_RD_STB: begin
                if (q_q.cnt == '0) begin
                    rd_done = 1'b1;
                    q_d.st  = ST_RD_HOLD;
                end else begin
                    q_d.cnt = q_q.cnt - 1'b1;
                end
            end
            ST_RD_HOLD: q_d.st = ST_WAIT_CONT;
            ST_WAIT_CONT: begin
                if (cont_flag) begin
                    cont_take = 1'b1;
                    q_d.st    = ST_IDLE;
                end
            end
            ST_WAIT_VS: begin
                if (frame_sync && !q_q.vs) q_d.st = ST_IDLE;
            end
            ST_DELAY: begin
                if (dly_done) q_d.st = ST_IDLE;
            end
            default: q_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '{st: ST_IDLE, cnt: '0, a0: 1'b0, dat: '0, vs: 1'b0};
        else        q_q <= q_d;
    end

    pcs_ms_delay #(.CYC_PER_MS(CYC_PER_MS)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .start (dly_start),
        .ms_in (w_dat),
        .done  (dly_done)
    );

    pcs_status u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_begin  (rd_begin),
        .rd_done   (rd_done),
        .rd_byte   (pnl_din),
        .rd_a0     (q_q.a0),
        .cont_set  (sw_continue),
        .cont_take (cont_take),
        .cmd_int   (cmd_int),
        .clr_rd    (sw_clr_rd),
        .clr_cmd   (sw_clr_cmd),
        .mask_rd   (mask_rd),
        .mask_cmd  (mask_cmd),
        .stat_word (rd_status),
        .cont_flag (cont_flag),
        .pend_rd   (pend_rd),
        .pend_cmd  (pend_cmd),
        .irq       (irq)
    );

    assign cmd_ready = (q_q.st == ST_IDLE);
    assign pnl_a0    = q_q.a0;
    assign pnl_dout  = q_q.dat;
    assign pnl_doe   = (q_q.st == ST_WR_SETUP) || (q_q.st == ST_WR_STB) || (q_q.st == ST_WR_HOLD);
    assign pnl_wr_n  = !(q_q.st == ST_WR_STB);
    assign pnl_rd_n  = !(q_q.st == ST_RD_STB);
endmodule

// File: rtl/pcs_checker.sv
module pcs_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic [15:0] cmd_word,
    input logic        cmd_ready,
    input logic        pnl_a0,
    input logic [7:0]  pnl_dout,
    input logic        pnl_doe,
    input logic        pnl_wr_n,
    input logic        pnl_rd_n,
    input logic [15:0] rd_status,
    input logic        pend_cmd,
    input logic        mask_rd,
    input logic        mask_cmd,
    input logic        irq
);
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!pnl_wr_n && !pnl_rd_n)); // R2
    AST_WR_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !pnl_wr_n |-> pnl_doe); // R2
    AST_WR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!pnl_wr_n && !$past(pnl_wr_n)) |-> ($stable(pnl_dout) && $stable(pnl_a0))); // R2
    AST_OK_LOW_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!pnl_rd_n && $past(pnl_rd_n)) |-> !rd_status[9]); // R3
    AST_ZERO_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_word[11:9] == 3'd6 && cmd_word[7:0] == 8'd0) |=> cmd_ready); // R6
    AST_CMD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_word[11:9] == 3'd5) |=> pend_cmd); // R7
    AST_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_rd && mask_cmd) |-> !irq); // R8
    AST_NOP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_word[11:9] == 3'd4) |=> cmd_ready); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (pnl_wr_n && pnl_rd_n && !pnl_doe)); // R10
endmodule

bind panel_cmd_seq pcs_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_word  (cmd_word),
    .cmd_ready (cmd_ready),
    .pnl_a0    (pnl_a0),
    .pnl_dout  (pnl_dout),
    .pnl_doe   (pnl_doe),
    .pnl_wr_n  (pnl_wr_n),
    .pnl_rd_n  (pnl_rd_n),
    .rd_status (rd_status),
    .pend_cmd  (pend_cmd),
    .mask_rd   (mask_rd),
    .mask_cmd  (mask_cmd),
    .irq       (irq)
);

// File: tb/panel_cmd_seq_tb.sv
module panel_cmd_seq_tb;
    localparam int SCYC = 2;
    localparam int CPM  = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [15:0] cmd_word = '0;
    logic [7:0]  pnl_din = '0;
    logic        frame_sync = 1'b0, sw_continue = 1'b0, sw_clr_rd = 1'b0, sw_clr_cmd = 1'b0;
    logic        mask_rd = 1'b0, mask_cmd = 1'b0;
    logic        cmd_ready, pnl_a0, pnl_doe, pnl_wr_n, pnl_rd_n, pend_rd, pend_cmd, irq;
    logic [7:0]  pnl_dout;
    logic [15:0] rd_status;

    int tests = 0, fails = 0;
    bit finished = 0;

    panel_cmd_seq #(.STROBE_CYC(SCYC), .CYC_PER_MS(CPM)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .cmd_ready(cmd_ready), .pnl_a0(pnl_a0), .pnl_dout(pnl_dout), .pnl_doe(pnl_doe),
        .pnl_din(pnl_din), .pnl_wr_n(pnl_wr_n), .pnl_rd_n(pnl_rd_n),
        .frame_sync(frame_sync), .sw_continue(sw_continue), .sw_clr_rd(sw_clr_rd),
        .sw_clr_cmd(sw_clr_cmd), .mask_rd(mask_rd), .mask_cmd(mask_cmd),
        .rd_status(rd_status), .pend_rd(pend_rd), .pend_cmd(pend_cmd), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    // queue entries, one per busy cycle:
    // 1 wr setup, 2 wr strobe, 3 wr hold, 4 rd setup, 5 rd strobe,
    // 6 rd strobe with capture, 7 rd hold, 8 delay
    int  q[$];
    bit  w_cont, w_vs, vs_prev, m_a0, s_a0, s_ok, s_cont, m_pr, m_pc;
    bit [7:0] m_dat, s_dat;

    function automatic bit m_ready();
        return (q.size() == 0) && !w_cont && !w_vs;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            w_cont = 0; w_vs = 0; vs_prev = 0; m_a0 = 0; s_a0 = 0; s_ok = 0;
            s_cont = 0; m_pr = 0; m_pc = 0; m_dat = 0; s_dat = 0;
        end else begin
            int  cur;
            bit  rdy, cap, take, rdbeg, cint;
            cur = (q.size() != 0) ? q[0] : 0;
            rdy = m_ready();
            cap = (cur == 6);
            take = 0; rdbeg = 0; cint = 0;
            if (w_cont && s_cont) begin take = 1; w_cont = 0; end
            if (w_vs && frame_sync && !vs_prev) w_vs = 0;
            vs_prev = frame_sync;
            if (q.size() != 0) begin
                int e;
                e = q.pop_front();
                if (e == 7) w_cont = 1;
            end
            if (rdy && cmd_valid) begin
                int op;
                op = int'(cmd_word[11:9]);
                if (op == 0) begin
                    m_a0 = cmd_word[8]; rdbeg = 1;
                    q.push_back(4);
                    for (int i = 0; i < SCYC - 1; i++) q.push_back(5);
                    q.push_back(6); q.push_back(7);
                end else if (op == 1 || (op == 2 && cmd_word[8])) begin
                    m_a0 = cmd_word[8]; m_dat = cmd_word[7:0];
                    q.push_back(1);
                    for (int i = 0; i < SCYC; i++) q.push_back(2);
                    q.push_back(3);
                end else if (op == 3) begin
                    w_vs = 1;
                end else if (op == 5) begin
                    cint = 1;
                end else if (op == 6) begin
                    for (int i = 0; i < int'(cmd_word[7:0]) * CPM; i++) q.push_back(8);
                end
            end
            if (rdbeg) begin s_ok = 0; s_cont = 0; end
            if (take) s_cont = 0;
            if (sw_continue) s_cont = 1;
            if (cap) begin s_dat = pnl_din; s_a0 = m_a0; s_ok = 1; end
            if (sw_clr_rd) m_pr = 0;
            if (cap) m_pr = 1;
            if (sw_clr_cmd) m_pc = 0;
            if (cint) m_pc = 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            int f;
            f = (q.size() != 0) ? q[0] : 0;
            chk("R10 cmd_ready", int'(cmd_ready), int'(m_ready()));
            chk("R2 wr_n", int'(pnl_wr_n), int'(f != 2));
            chk("R2 doe", int'(pnl_doe), int'(f >= 1 && f <= 3));
            chk("R2 dout", int'(pnl_dout), int'(m_dat));
            chk("R2 a0", int'(pnl_a0), int'(m_a0));
            chk("R3 rd_n", int'(pnl_rd_n), int'(!(f == 5 || f == 6)));
            chk("R3 rd_status", int'(rd_status), int'({5'b0, s_cont, s_ok, s_a0, s_dat}));
            chk("R3 pend_rd", int'(pend_rd), int'(m_pr));
            chk("R7 pend_cmd", int'(pend_cmd), int'(m_pc));
            chk("R8 irq", int'(irq), int'((m_pr && !mask_rd) || (m_pc && !mask_cmd)));
        end
    end

    // ---------------- stimulus ----------------
    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic send(input logic [15:0] w);
        while (!cmd_ready) step();
        cmd_valid = 1'b1;
        cmd_word  = w;
        step();
        cmd_valid = 1'b0;
    endtask

    task automatic busy(output int n);
        n = 0;
        while (!cmd_ready && n < 10000) begin
            n++;
            step();
        end
    endtask

    task automatic pulse_cont();
        sw_continue = 1'b1;
        step();
        sw_continue = 1'b0;
    endtask

    initial begin
        int n;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 ready", int'(cmd_ready), 1);
        chk("R1 strobes", int'({pnl_wr_n, pnl_rd_n, pnl_doe}), 3'b110);
        chk("R1 status", int'(rd_status), 0);
        chk("R1 flags", int'({pend_rd, pend_cmd, irq}), 0);

        // R2 writes: command byte, data byte, frame data
        send(16'h0234); busy(n); chk("R2 write busy", n, SCYC + 2);
        chk("R2 dout", int'(pnl_dout), 8'h34);
        send(16'h03A5); busy(n); chk("R2 data write busy", n, SCYC + 2);
        send(16'h05C3); busy(n); chk("R2 frame write busy", n, SCYC + 2);
        chk("R2 frame a0", int'(pnl_a0), 1);

        // R9 no-op encodings
        send(16'h0800); busy(n); chk("R9 op4 busy", n, 0);
        send(16'h0E00); busy(n); chk("R9 op7 busy", n, 0);
        send(16'h0411); busy(n); chk("R9 op2 a0=0 busy", n, 0);
        chk("R9 dout kept", int'(pnl_dout), 8'hC3);
        chk("R9 a0 kept", int'(pnl_a0), 1);
        chk("R9 no flag", int'(pend_cmd), 0);

        // R7 / R8 command interrupt
        send(16'h0A00); busy(n); chk("R7 irq op busy", n, 0);
        chk("R7 pend_cmd", int'(pend_cmd), 1);
        chk("R8 irq", int'(irq), 1);
        mask_cmd = 1'b1; step();
        chk("R8 masked", int'(irq), 0);
        sw_clr_cmd = 1'b1; step(); sw_clr_cmd = 1'b0;
        chk("R8 cleared", int'(pend_cmd), 0);
        mask_cmd = 1'b0;

        // R3 / R4 status read
        pnl_din = 8'h5A;
        send(16'h0000);
        repeat (6) step();
        chk("R4 stalled", int'(cmd_ready), 0);
        chk("R3 status", int'(rd_status), 16'h025A);
        chk("R3 pend_rd", int'(pend_rd), 1);
        pulse_cont();
        chk("R4 flag seen", int'(rd_status[10]), 1);
        chk("R4 still stalled", int'(cmd_ready), 0);
        step();
        chk("R4 resumed", int'(cmd_ready), 1);
        chk("R4 flag consumed", int'(rd_status), 16'h025A);

        // R4 early continue discarded; R3 frame-buffer read
        pulse_cont();
        chk("R4 early flag", int'(rd_status[10]), 1);
        pnl_din = 8'h99;
        send(16'h0100);
        chk("R3 ok cleared", int'(rd_status[9]), 0);
        repeat (6) step();
        chk("R4 early flag ignored", int'(cmd_ready), 0);
        chk("R3 fb status", int'(rd_status), 16'h0399);
        pulse_cont(); step();
        chk("R4 resumed 2", int'(cmd_ready), 1);

        // R5 vsync rising edge
        frame_sync = 1'b1; step();
        send(16'h0600);
        repeat (4) step();
        chk("R5 level ignored", int'(cmd_ready), 0);
        frame_sync = 1'b0;
        repeat (2) step();
        chk("R5 low waits", int'(cmd_ready), 0);
        frame_sync = 1'b1; step();
        chk("R5 edge done", int'(cmd_ready), 1);
        frame_sync = 1'b0;

        // R6 delays
        send(16'h0C03); busy(n); chk("R6 delay 3", n, 3 * CPM);
        send(16'h0C00); busy(n); chk("R6 delay 0", n, 0);
        send(16'h0C01); busy(n); chk("R6 delay 1", n, CPM);

        // R8 read mask, clear, and set-wins
        mask_rd = 1'b1; step();
        chk("R8 rd masked", int'(irq), 0);
        sw_clr_rd = 1'b1; step(); sw_clr_rd = 1'b0;
        chk("R8 rd cleared", int'(pend_rd), 0);
        mask_rd = 1'b0;
        sw_clr_cmd = 1'b1;
        send(16'h0A00);
        sw_clr_cmd = 1'b0;
        chk("R8 set wins", int'(pend_cmd), 1);
        repeat (3) step();

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule